// File: doc/BRIEF.md
# Saturating Bit Node for Parallel Belief-Propagation Decoding

This block is one variable (bit) node of a fully parallel sum-product decoder for low-density parity-check codes. It holds the soft channel value of its code bit. On each decoding step it takes in N check-to-bit messages and sends N bit-to-check messages back. Each outgoing message on an edge is the channel value plus every incoming message except the one that arrived on that same edge. The node also gives the total a-posteriori value and a hard bit decision, which a separate syndrome check can use.

Incoming messages are in sign-magnitude form. The node turns each into a wider two's complement number. It adds all of them to the channel value once, then takes each edge's own term back out. Every result is clamped back into the narrow message width. Messages have W bits, with the lowest bit being one half.

Top module: `llr_bit_node`

## Requirements
- R1: While `rst_n` is low, the stored channel value, every edge output, `post_llr` and `hard_bit` are cleared to zero.
- R2: A cycle with `chan_load` high stores `chan_llr` (two's complement) as the channel value. When `chan_load` is low, the stored value holds. A step taken in the same cycle as a load uses the value that was stored before that load.
- R3: Each incoming message k sits at `c2b_sm[k*W +: W]`. Bit W-1 is the sign (1 = negative) and the low W-1 bits are the magnitude. A negative zero counts as zero.
- R4: For each edge k, the output `b2c_msg[k*W +: W]` is the channel value plus the sum of all incoming messages other than message k. The sum is formed without overflow in W+clog2(N+1) bits.
- R5: `post_llr` is the channel value plus all N incoming messages.
- R6: Any result above 2^(W-1)-1 is clamped to 2^(W-1)-1, which is 0111 (+3.5) for W=4. Any result below -2^(W-1) is clamped to -2^(W-1), which is 1000 (-4.0). All other results pass through unchanged.
- R7: `hard_bit` is 1 when the unclamped total is negative. It is 0 when the total is positive or exactly zero.
- R8: The edge outputs, `post_llr` and `hard_bit` update only on a rising edge where `step_en` is high. They keep their values at every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_load | input | 1 | Strobe that stores the channel value |
| chan_llr | input | W | Channel value, two's complement |
| step_en | input | 1 | Computes and registers the outputs |
| c2b_sm | input | N*W | Incoming check messages, sign-magnitude |
| b2c_msg | output | N*W | Outgoing bit messages, two's complement |
| post_llr | output | W | Clamped a-posteriori value |
| hard_bit | output | 1 | Hard decision |

## Verification
The only internal state is the stored channel value, so any fault in it shows up on the first step that follows. The easiest way to see it is a step with all incoming messages at zero: every edge output and `post_llr` must then equal the stored value exactly. Mistakes in the exclusion term, the clamp limits or the sign handling show up in the very next registered outputs. The bench therefore uses saturating input patterns, mixed-sign patterns and negative-zero patterns to expose them.

// File: rtl/llr_bit_node.sv
module llr_bit_node #(
  parameter int W = 4,
  parameter int N = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           chan_load,
  input  logic [W-1:0]   chan_llr,
  input  logic           step_en,
  input  logic [N*W-1:0] c2b_sm,
  output logic [N*W-1:0] b2c_msg,
  output logic [W-1:0]   post_llr,
  output logic           hard_bit
);
  localparam int EW = W + $clog2(N + 1);
  localparam logic signed [EW-1:0] MAXV = EW'((1 << (W - 1)) - 1);
  localparam logic signed [EW-1:0] MINV = -EW'(1 << (W - 1));

  logic        [W-1:0]  chan_q;
  logic signed [EW-1:0] ext [N];
  logic signed [EW-1:0] total;
  logic        [W-1:0]  edge_d [N];

  function automatic logic [W-1:0] clamp(input logic signed [EW-1:0] v);
    if (v > MAXV)      return MAXV[W-1:0];
    else if (v < MINV) return MINV[W-1:0];
    else               return v[W-1:0];
  endfunction

  for (genvar k = 0; k < N; k++) begin : g_conv
    logic signed [EW-1:0] mag;
    assign mag    = $signed({{(EW-W+1){1'b0}}, c2b_sm[k*W +: W-1]});
    assign ext[k] = c2b_sm[k*W + W-1] ? -mag : mag;
  end

  always_comb begin
    total = $signed({{(EW-W){chan_q[W-1]}}, chan_q});
    for (int k = 0; k < N; k++) total = total + ext[k];
    for (int k = 0; k < N; k++) edge_d[k] = clamp(total - ext[k]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chan_q   <= '0;
      b2c_msg  <= '0;
      post_llr <= '0;
      hard_bit <= 1'b0;
    end else begin
      if (chan_load) chan_q <= chan_llr;
      if (step_en) begin
        for (int k = 0; k < N; k++) b2c_msg[k*W +: W] <= edge_d[k];
        post_llr <= clamp(total);
        hard_bit <= total[EW-1];
      end
    end
  end
endmodule

module llr_bit_node_chk #(
  parameter int W = 4,
  parameter int N = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           chan_load,
  input logic [W-1:0]   chan_llr,
  input logic           step_en,
  input logic [N*W-1:0] c2b_sm,
  input logic [W-1:0]   chan_q,
  input logic [N*W-1:0] b2c_msg,
  input logic [W-1:0]   post_llr,
  input logic           hard_bit
);
  localparam logic [W-1:0] MAG_MASK = {1'b0, {(W-1){1'b1}}};
  logic zero_in;

  always_comb begin
    zero_in = 1'b1;
    for (int k = 0; k < N; k++)
      if ((c2b_sm[k*W +: W] & MAG_MASK) != '0) zero_in = 1'b0;
  end

  AST_CHAN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    chan_load |=> chan_q == $past(chan_llr)); // R2
  AST_CHAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_load |=> $stable(chan_q)); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(b2c_msg) && $stable(post_llr) && $stable(hard_bit)); // R8
  AST_HARD_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    hard_bit == post_llr[W-1]); // R7
  AST_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && zero_in |=> post_llr == $past(chan_q) && b2c_msg == {N{$past(chan_q)}}); // R3
endmodule

bind llr_bit_node llr_bit_node_chk #(.W(W), .N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_load(chan_load), .chan_llr(chan_llr),
  .step_en(step_en), .c2b_sm(c2b_sm), .chan_q(chan_q), .b2c_msg(b2c_msg),
  .post_llr(post_llr), .hard_bit(hard_bit));

// File: tb/llr_bit_node_bench.sv
module llr_bit_node_bench;
  localparam int W = 4;
  localparam int N = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           chan_load = 1'b0;
  logic [W-1:0]   chan_llr = '0;
  logic           step_en = 1'b0;
  logic [N*W-1:0] c2b_sm = '0;
  logic [N*W-1:0] b2c_msg;
  logic [W-1:0]   post_llr;
  logic           hard_bit;

  int tests = 0;
  int fails = 0;
  int model_chan = 0;

  always #10 clk = ~clk;

  llr_bit_node #(.W(W), .N(N)) u_llr_bit_node (.*);

  function automatic int sm_val(input logic [W-1:0] v);
    return v[W-1] ? -int'(v[W-2:0]) : int'(v[W-2:0]);
  endfunction

  function automatic int clampi(input int v);
    if (v > 7) return 7;
    if (v < -8) return -8;
    return v;
  endfunction

  function automatic int tc(input logic [W-1:0] v);
    return int'($signed(v));
  endfunction

  task automatic check(input string req, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic check_outputs(input string req, input logic [N*W-1:0] msgs);
    int total = model_chan;
    for (int k = 0; k < N; k++) total += sm_val(msgs[k*W +: W]);
    for (int k = 0; k < N; k++)
      check(req, tc(b2c_msg[k*W +: W]), clampi(total - sm_val(msgs[k*W +: W])));
    check(req, tc(post_llr), clampi(total));
    check(req, int'(hard_bit), (total < 0) ? 1 : 0);
  endtask

  task automatic load_chan(input logic [W-1:0] v);
    @(negedge clk);
    chan_load = 1'b1; chan_llr = v;
    @(negedge clk);
    chan_load = 1'b0;
    model_chan = tc(v);
  endtask

  task automatic step(input string req, input logic [N*W-1:0] msgs);
    @(negedge clk);
    c2b_sm = msgs; step_en = 1'b1;
    @(negedge clk);
    step_en = 1'b0;
    check_outputs(req, msgs);
  endtask

  task automatic t_reset;
    check("R1", int'(b2c_msg), 0);
    check("R1", int'(post_llr), 0);
    check("R1", int'(hard_bit), 0);
    step("R1", '0);
  endtask

  task automatic t_mixed;
    load_chan(4'b0011);
    step("R4", {4'b0000, 4'b1001, 4'b0010});
    load_chan(4'b1110);
    step("R5", {4'b0011, 4'b1100, 4'b0001});
  endtask

  task automatic t_saturate;
    load_chan(4'b0111);
    step("R6", {4'b0111, 4'b0111, 4'b0111});
    load_chan(4'b1000);
    step("R6", {4'b1111, 4'b1111, 4'b1111});
  endtask

  task automatic t_zero_sign;
    load_chan(4'b0000);
    step("R7", {4'b1000, 4'b1101, 4'b0101});
    check("R7", int'(hard_bit), 0);
    load_chan(4'b1111);
    step("R7", '0);
    check("R7", int'(hard_bit), 1);
  endtask

  task automatic t_neg_zero;
    load_chan(4'b0010);
    step("R3", {4'b1000, 4'b1000, 4'b1000});
    check("R3", tc(post_llr), 2);
  endtask

  task automatic t_hold;
    logic [N*W-1:0] keep_msg = b2c_msg;
    logic [W-1:0] keep_post = post_llr;
    @(negedge clk);
    c2b_sm = {4'b0111, 4'b1111, 4'b0101};
    chan_load = 1'b1; chan_llr = 4'b0110;
    @(negedge clk);
    chan_load = 1'b0;
    @(negedge clk);
    check("R8", int'(b2c_msg), int'(keep_msg));
    check("R8", int'(post_llr), int'(keep_post));
    model_chan = 6;
    step("R2", '0);
  endtask

  task automatic t_load_with_step;
    load_chan(4'b0001);
    @(negedge clk);
    chan_load = 1'b1; chan_llr = 4'b1010;
    c2b_sm = '0; step_en = 1'b1;
    @(negedge clk);
    chan_load = 1'b0; step_en = 1'b0;
    check("R2", tc(post_llr), 1);
    model_chan = -6;
    step("R2", '0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mixed();
        t_saturate();
        t_zero_sign();
        t_neg_zero();
        t_hold();
        t_load_with_step();
      end
      begin
        repeat (5000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule